// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recently used page translations so that most memory references skip the two-level table walk. It holds 32 translations as 8 sets of 4 ways. A lookup presents a 32-bit linear address. The block selects one set, compares the 20-bit page number against the four ways of that set, and returns a registered result one cycle later. On a hit the result is a 32-bit physical address and the cached dirty, user and writable flags. On a miss the result is a walk request carrying the page number. The walker later returns the translation through the fill port.

A write to a clean page is reported as a miss, even when the page is cached. This lets the walker set the dirty flag and refill the entry. Refilling a page that is already cached overwrites the same way, so a page never occupies two ways. Replacement fills an empty way first; when the set is full it uses a 3-bit tree pseudo-LRU per set. A pulse on the flush input, raised when the page-directory base changes, empties the whole cache.

Top module: `xlat_cache`

## Requirements
- R1: After reset no response is pending, and every lookup misses until a fill has been made.
- R2: A lookup sampled on one clock edge produces exactly one response, with rsp_valid_o high, in the following cycle. No response appears without a lookup.
- R3: A lookup hits when one valid way of set lk_addr_i[14:12] holds page number lk_addr_i[31:12]. At most one way of a set matches.
- R4: On a hit, rsp_paddr_o is {cached frame, lk_addr_i[11:0]} and the dirty, user and writable outputs show the cached flags. On a miss, the address and the flags are zero.
- R5: On a miss, walk_req_o is high and walk_vpn_o is lk_addr_i[31:12]. On a hit, walk_req_o is low and walk_vpn_o is zero.
- R6: A write lookup (lk_write_i=1) that matches an entry whose dirty flag is clear is reported as a miss with a walk request. A write to a dirty entry, and any read of a matching entry, hits.
- R7: A fill whose page is already cached in its set overwrites that way. Otherwise the fill takes the lowest-numbered invalid way, and only when all four ways are valid does it take the pseudo-LRU victim.
- R8: Each set has three tree bits. Bit 0 chooses the victim pair (0 gives ways 0/1, 1 gives ways 2/3), bit 1 chooses within 0/1 and bit 2 within 2/3. A hit or a fill on a way points the bits away from that way. A miss does not change the bits.
- R9: All 32 entries are usable. Four pages mapping to one set are held together, and 32 pages spread over all 8 sets (128 KB) all hit.
- R10: A flush invalidates all 32 entries. A lookup in the flush cycle misses, and a fill in the flush cycle is discarded.
- R11: When a fill and a lookup address the same set in the same cycle, the fill is written and the lookup reports a miss. A lookup to a different set in that cycle is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate every entry (directory base written) |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Linear address to translate |
| lk_write_i | input | 1 | Lookup is for a write access |
| fill_valid_i | input | 1 | Walker delivers a translation |
| fill_vpn_i | input | 20 | Page number of the fill |
| fill_pfn_i | input | 20 | Physical frame of the fill |
| fill_dirty_i | input | 1 | Dirty flag of the fill |
| fill_user_i | input | 1 | User-accessible flag of the fill |
| fill_writable_i | input | 1 | Writable flag of the fill |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_paddr_o | output | 32 | Physical address on a hit |
| rsp_dirty_o | output | 1 | Cached dirty flag on a hit |
| rsp_user_o | output | 1 | Cached user flag on a hit |
| rsp_writable_o | output | 1 | Cached writable flag on a hit |
| walk_req_o | output | 1 | Walk request on a miss |
| walk_vpn_o | output | 20 | Page number the walker must fetch |

## Verification
The bench fills one set past its capacity through a fixed pattern of hits and evictions. A wrong tree update, or a replacement that skips empty ways, would then evict a page the expected order keeps. Writes to clean cached pages must come back as misses; a design that ignored the dirty flag would hit and the page would never be marked. The bench puts a flush on the same cycle as a lookup and on the same cycle as a fill, and puts a fill on the same cycle as a lookup to the same set and to another set. A design with the wrong priority would return stale hits or keep an entry it should have dropped. A refill of a cached page must replace it in place; a duplicate way would show up as a stale frame or a dirty flag that stays clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int OFF_W = 12;
    localparam int WAYS  = 4;
    localparam int SETS  = 8;

    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int LRU_W = WAYS - 1;

    // 24-bit tag: valid, three attribute flags, page number
    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             user;
        logic             writable;
        logic [VPN_W-1:0] vpn;
    } tag_t;

    typedef struct packed {
        tag_t             tag;
        logic [PFN_W-1:0] pfn;
    } entry_t;

    typedef logic [IDX_W-1:0] set_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [LRU_W-1:0] lru_t;

    function automatic set_t set_of(input logic [VPN_W-1:0] vpn);
        return vpn[IDX_W-1:0];
    endfunction

    // bit0 picks pair, bit1 inside ways 0/1, bit2 inside ways 2/3
    function automatic way_t lru_victim(input lru_t b);
        if (b[0]) return b[2] ? way_t'(3) : way_t'(2);
        return b[1] ? way_t'(1) : way_t'(0);
    endfunction

    function automatic lru_t lru_touch(input lru_t b, input way_t w);
        lru_t r;
        r = b;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction

    // returns {found, index of lowest clear bit}
    function automatic logic [WAY_W:0] first_free(input logic [WAYS-1:0] v);
        logic [WAY_W:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!v[i]) r = {1'b1, way_t'(i)};
        end
        return r;
    endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush_i,
    input  logic   wr_en_i,
    input  set_t   wr_set_i,
    input  way_t   wr_way_i,
    input  entry_t wr_entry_i,
    input  set_t   rd_a_set_i,
    output entry_t rd_a_o [WAYS],
    input  set_t   rd_b_set_i,
    output entry_t rd_b_o [WAYS]
);

    entry_t mem [SETS][WAYS];
    logic [SETS*WAYS-1:0] valid_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem[s][w] <= '0;
        end else if (flush_i) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem[s][w].tag.valid <= 1'b0;
        end else if (wr_en_i) begin
            mem[wr_set_i][wr_way_i] <= wr_entry_i;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_a_o[w] = mem[rd_a_set_i][w];
        assign rd_b_o[w] = mem[rd_b_set_i][w];
    end

    for (genvar s = 0; s < SETS; s++) begin : g_vs
        for (genvar w = 0; w < WAYS; w++) begin : g_vw
            assign valid_flat[s*WAYS+w] = mem[s][w].tag.valid;
        end
    end

    // R10: one cycle after a flush nothing is valid
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> ($countones(valid_flat) == 0));

endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  logic [WAYS-1:0]  valid_i,
    input  logic [VPN_W-1:0] vpn_i [WAYS],
    input  logic [VPN_W-1:0] key_i,
    output logic [WAYS-1:0]  hit_vec_o,
    output logic             hit_o,
    output way_t             hit_way_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_i[w] && (vpn_i[w] == key_i);
    end

    assign hit_o = |hit_vec_o;

    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) hit_way_o = way_t'(w);
        end
    end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit_en_i,
    input  set_t hit_set_i,
    input  way_t hit_way_i,
    input  logic fill_en_i,
    input  set_t fill_set_i,
    input  way_t fill_way_i,
    input  set_t victim_set_i,
    output way_t victim_o
);

    lru_t bits [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) bits[s] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (fill_en_i && fill_set_i == set_t'(s))
                    bits[s] <= lru_touch(bits[s], fill_way_i);
                else if (hit_en_i && hit_set_i == set_t'(s))
                    bits[s] <= lru_touch(bits[s], hit_way_i);
            end
        end
    end

    assign victim_o = lru_victim(bits[victim_set_i]);

    // R11: a hit and a fill never touch the same set in one cycle
    a_r11_touch_apart: assert property (@(posedge clk) disable iff (rst)
        (hit_en_i && fill_en_i) |-> (hit_set_i != fill_set_i));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             lk_valid_i,
    input  logic [VA_W-1:0]  lk_addr_i,
    input  logic             lk_write_i,
    input  logic             fill_valid_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PFN_W-1:0] fill_pfn_i,
    input  logic             fill_dirty_i,
    input  logic             fill_user_i,
    input  logic             fill_writable_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic             rsp_dirty_o,
    output logic             rsp_user_o,
    output logic             rsp_writable_o,
    output logic             walk_req_o,
    output logic [VPN_W-1:0] walk_vpn_o
);

    logic [VPN_W-1:0] lk_vpn;
    set_t             lk_set, fill_set;
    entry_t           rd_lk [WAYS];
    entry_t           rd_fl [WAYS];
    logic [WAYS-1:0]  lk_valids, fl_valids;
    logic [VPN_W-1:0] lk_vpns [WAYS];
    logic [VPN_W-1:0] fl_vpns [WAYS];
    logic [WAYS-1:0]  lk_hit_vec, fl_hit_vec;
    logic             lk_match, fl_match;
    way_t             lk_way, fl_way, victim, fill_way;
    logic [WAY_W:0]   free;
    logic             fill_go, set_clash, wr_clean, lk_hit;
    entry_t           fill_entry;

    assign lk_vpn   = lk_addr_i[VA_W-1:OFF_W];
    assign lk_set   = set_of(lk_vpn);
    assign fill_set = set_of(fill_vpn_i);

    xlat_store u_store (
        .clk        (clk),
        .rst        (rst),
        .flush_i    (flush_i),
        .wr_en_i    (fill_go),
        .wr_set_i   (fill_set),
        .wr_way_i   (fill_way),
        .wr_entry_i (fill_entry),
        .rd_a_set_i (lk_set),
        .rd_a_o     (rd_lk),
        .rd_b_set_i (fill_set),
        .rd_b_o     (rd_fl)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_split
        assign lk_valids[w] = rd_lk[w].tag.valid;
        assign lk_vpns[w]   = rd_lk[w].tag.vpn;
        assign fl_valids[w] = rd_fl[w].tag.valid;
        assign fl_vpns[w]   = rd_fl[w].tag.vpn;
    end

    xlat_match u_lk_match (
        .valid_i   (lk_valids),
        .vpn_i     (lk_vpns),
        .key_i     (lk_vpn),
        .hit_vec_o (lk_hit_vec),
        .hit_o     (lk_match),
        .hit_way_o (lk_way)
    );

    xlat_match u_fl_match (
        .valid_i   (fl_valids),
        .vpn_i     (fl_vpns),
        .key_i     (fill_vpn_i),
        .hit_vec_o (fl_hit_vec),
        .hit_o     (fl_match),
        .hit_way_o (fl_way)
    );

    xlat_lru u_lru (
        .clk          (clk),
        .rst          (rst),
        .hit_en_i     (lk_hit),
        .hit_set_i    (lk_set),
        .hit_way_i    (lk_way),
        .fill_en_i    (fill_go),
        .fill_set_i   (fill_set),
        .fill_way_i   (fill_way),
        .victim_set_i (fill_set),
        .victim_o     (victim)
    );

    // fill placement: same page in place, else empty way, else tree victim
    assign free    = first_free(fl_valids);
    assign fill_go = fill_valid_i && !flush_i;

    always_comb begin
        if (fl_match)          fill_way = fl_way;
        else if (free[WAY_W])  fill_way = free[WAY_W-1:0];
        else                   fill_way = victim;
    end

    always_comb begin
        fill_entry.tag.valid    = 1'b1;
        fill_entry.tag.dirty    = fill_dirty_i;
        fill_entry.tag.user     = fill_user_i;
        fill_entry.tag.writable = fill_writable_i;
        fill_entry.tag.vpn      = fill_vpn_i;
        fill_entry.pfn          = fill_pfn_i;
    end

    assign set_clash = fill_valid_i && (fill_set == lk_set);
    assign wr_clean  = lk_write_i && !rd_lk[lk_way].tag.dirty;
    assign lk_hit    = lk_valid_i && lk_match && !wr_clean && !set_clash && !flush_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o    <= 1'b0;
            rsp_hit_o      <= 1'b0;
            rsp_paddr_o    <= '0;
            rsp_dirty_o    <= 1'b0;
            rsp_user_o     <= 1'b0;
            rsp_writable_o <= 1'b0;
            walk_req_o     <= 1'b0;
            walk_vpn_o     <= '0;
        end else begin
            rsp_valid_o    <= lk_valid_i;
            rsp_hit_o      <= lk_hit;
            rsp_paddr_o    <= lk_hit ? {rd_lk[lk_way].pfn, lk_addr_i[OFF_W-1:0]} : '0;
            rsp_dirty_o    <= lk_hit && rd_lk[lk_way].tag.dirty;
            rsp_user_o     <= lk_hit && rd_lk[lk_way].tag.user;
            rsp_writable_o <= lk_hit && rd_lk[lk_way].tag.writable;
            walk_req_o     <= lk_valid_i && !lk_hit;
            walk_vpn_o     <= (lk_valid_i && !lk_hit) ? lk_vpn : '0;
        end
    end

    // R3: fills never leave a page in two ways of a set
    a_r3_single_way: assert property (@(posedge clk) disable iff (rst)
        lk_valid_i |-> $onehot0(lk_hit_vec));

    // R4: the page offset passes through untouched on a hit
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_hit_o |-> (rsp_paddr_o[OFF_W-1:0] == $past(lk_addr_i[OFF_W-1:0])));

    // R6: a write only hits an entry already marked dirty
    a_r6_write_dirty: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit_o && $past(lk_write_i)) |-> rsp_dirty_o);

    // R10: lookups in a flush cycle miss
    a_r10_flush_lookup: assert property (@(posedge clk) disable iff (rst)
        (lk_valid_i && flush_i) |=> (walk_req_o && !rsp_hit_o));

    // R11: a lookup colliding with a same-set fill misses
    a_r11_clash_miss: assert property (@(posedge clk) disable iff (rst)
        (lk_valid_i && set_clash) |=> walk_req_o);

    // R5: every response is either a hit or a walk request
    a_r5_hit_or_walk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> (rsp_hit_o != walk_req_o));

endmodule

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_dirty = 1'b0, fill_user = 1'b0, fill_writable = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_dirty, rsp_user, rsp_writable, walk_req;
    logic [31:0] rsp_paddr;
    logic [19:0] walk_vpn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic        hit;
        logic [31:0] paddr;
        logic [2:0]  attr;   // {dirty, user, writable}
        logic [19:0] vpn;
    } exp_t;

    exp_t  exp_q [$];
    string req_q [$];

    always #2.5 clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst(rst), .flush_i(flush),
        .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_write_i(lk_write),
        .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
        .fill_dirty_i(fill_dirty), .fill_user_i(fill_user), .fill_writable_i(fill_writable),
        .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_paddr_o(rsp_paddr),
        .rsp_dirty_o(rsp_dirty), .rsp_user_o(rsp_user), .rsp_writable_o(rsp_writable),
        .walk_req_o(walk_req), .walk_vpn_o(walk_vpn)
    );

    // set fill inputs for the current cycle without advancing time
    task automatic fill_arm(input logic [19:0] v, input logic [19:0] f, input logic [2:0] a);
        fill_valid = 1'b1; fill_vpn = v; fill_pfn = f;
        {fill_dirty, fill_user, fill_writable} = a;
    endtask

    task automatic fill_disarm();
        fill_valid = 1'b0; fill_dirty = 1'b0; fill_user = 1'b0; fill_writable = 1'b0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] f, input logic [2:0] a);
        fill_arm(v, f, a);
        @(negedge clk);
        fill_disarm();
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // driver: one lookup, expected result pushed to the scoreboard
    task automatic lookup(input logic [19:0] v, input logic [11:0] off, input logic wr,
                          input logic hit, input logic [19:0] f, input logic [2:0] a,
                          input string req);
        exp_t e;
        lk_valid = 1'b1; lk_addr = {v, off}; lk_write = wr;
        e.hit   = hit;
        e.paddr = hit ? {f, off} : 32'h0;
        e.attr  = hit ? a : 3'b000;
        e.vpn   = hit ? 20'h0 : v;
        exp_q.push_back(e);
        req_q.push_back(req);
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    // monitor: pops one expectation per response
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (exp_q.size() > 0) begin
                    exp_t  e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    checks++;
                    if (!rsp_valid) begin
                        fails++;
                        $display("FAIL %s (R2): no response, got valid=%0b expected 1", r, rsp_valid);
                    end else if (rsp_hit !== e.hit || rsp_paddr !== e.paddr ||
                                 {rsp_dirty, rsp_user, rsp_writable} !== e.attr ||
                                 walk_req !== !e.hit || walk_vpn !== e.vpn) begin
                        fails++;
                        $display("FAIL %s: hit=%0b paddr=%h attr=%b walk=%0b vpn=%h expected hit=%0b paddr=%h attr=%b walk=%0b vpn=%h",
                                 r, rsp_hit, rsp_paddr, {rsp_dirty, rsp_user, rsp_writable},
                                 walk_req, walk_vpn, e.hit, e.paddr, e.attr, !e.hit, e.vpn);
                    end
                end else if (rsp_valid) begin
                    checks++;
                    fails++;
                    $display("FAIL R2: response without lookup, got valid=%0b expected 0", rsp_valid);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (rsp_valid !== 1'b0 || walk_req !== 1'b0 || rsp_paddr !== 32'h0) begin
            fails++;
            $display("FAIL R1: valid=%0b walk=%0b paddr=%h expected 0 0 0", rsp_valid, walk_req, rsp_paddr);
        end
        lookup(20'h03010, 12'h08A, 1'b0, 1'b0, 20'h0, 3'b000, "R1 R5 empty miss");

        // R3 R4: basic hit with offset join
        fill(20'h03010, 20'h03000, 3'b011);
        lookup(20'h03010, 12'h08A, 1'b0, 1'b1, 20'h03000, 3'b011, "R3 R4 read hit");
        lookup(20'h03010, 12'hFFF, 1'b0, 1'b1, 20'h03000, 3'b011, "R4 offset fff");
        // R6: write to clean page misses
        lookup(20'h03010, 12'h010, 1'b1, 1'b0, 20'h0, 3'b000, "R6 write clean");
        // R7: refill in place with dirty set
        fill(20'h03010, 20'h03000, 3'b111);
        lookup(20'h03010, 12'h010, 1'b1, 1'b1, 20'h03000, 3'b111, "R6 R7 write dirty");

        // R7 R8 R9: fill set 0 and walk the tree
        fill(20'h00008, 20'h40008, 3'b011);
        fill(20'h00010, 20'h40010, 3'b011);
        fill(20'h00018, 20'h40018, 3'b011);
        lookup(20'h03010, 12'h001, 1'b0, 1'b1, 20'h03000, 3'b111, "R9 set0 way A");
        lookup(20'h00008, 12'h002, 1'b0, 1'b1, 20'h40008, 3'b011, "R9 set0 way B");
        lookup(20'h00010, 12'h003, 1'b0, 1'b1, 20'h40010, 3'b011, "R9 set0 way C");
        lookup(20'h00018, 12'h004, 1'b0, 1'b1, 20'h40018, 3'b011, "R9 set0 way D");
        // tree now 000: victim way0 (A)
        fill(20'h00020, 20'h40020, 3'b011);
        lookup(20'h03010, 12'h08A, 1'b0, 1'b0, 20'h0, 3'b000, "R8 A evicted");
        // tree b0=1 b2=0: victim way2 (C)
        fill(20'h00028, 20'h40028, 3'b011);
        lookup(20'h00010, 12'h000, 1'b0, 1'b0, 20'h0, 3'b000, "R8 C evicted");
        lookup(20'h00008, 12'h100, 1'b0, 1'b1, 20'h40008, 3'b011, "R8 B kept");
        lookup(20'h00018, 12'h200, 1'b0, 1'b1, 20'h40018, 3'b011, "R8 D kept");
        lookup(20'h00020, 12'h300, 1'b0, 1'b1, 20'h40020, 3'b011, "R8 E kept");
        lookup(20'h00028, 12'h400, 1'b0, 1'b1, 20'h40028, 3'b011, "R8 F kept");
        // tree b0=0 b1=1: victim way1 (B)
        fill(20'h00030, 20'h40030, 3'b011);
        lookup(20'h00008, 12'h100, 1'b0, 1'b0, 20'h0, 3'b000, "R8 B evicted");
        lookup(20'h00018, 12'h200, 1'b0, 1'b1, 20'h40018, 3'b011, "R7 D kept");
        lookup(20'h00020, 12'h300, 1'b0, 1'b1, 20'h40020, 3'b011, "R7 E kept");
        lookup(20'h00028, 12'h400, 1'b0, 1'b1, 20'h40028, 3'b011, "R7 F kept");
        lookup(20'h00030, 12'h500, 1'b0, 1'b1, 20'h40030, 3'b011, "R7 G new");

        // R10: flush then miss
        do_flush();
        lookup(20'h00018, 12'h200, 1'b0, 1'b0, 20'h0, 3'b000, "R10 after flush");

        // R9: 32 pages across every set
        for (int i = 0; i < 32; i++) fill(20'h10000 + 20'(i), 20'h20000 + 20'(i), 3'b001);
        for (int i = 0; i < 32; i++)
            lookup(20'h10000 + 20'(i), 12'(i * 13), 1'b0, 1'b1, 20'h20000 + 20'(i), 3'b001, "R9 full capacity");

        // R10: lookup in flush cycle misses
        flush = 1'b1;
        lookup(20'h10005, 12'h055, 1'b0, 1'b0, 20'h0, 3'b000, "R10 lookup during flush");
        flush = 1'b0;
        lookup(20'h10006, 12'h066, 1'b0, 1'b0, 20'h0, 3'b000, "R10 entries gone");
        // R10: fill in flush cycle discarded
        flush = 1'b1;
        fill(20'h10001, 20'h20001, 3'b001);
        flush = 1'b0;
        lookup(20'h10001, 12'h011, 1'b0, 1'b0, 20'h0, 3'b000, "R10 fill dropped");

        // R11: fill and lookup in same set
        fill(20'h10000, 20'h20000, 3'b001);
        lookup(20'h10000, 12'h0AA, 1'b0, 1'b1, 20'h20000, 3'b001, "R11 setup hit");
        fill_arm(20'h10008, 20'h20008, 3'b101);
        lookup(20'h10000, 12'h0AB, 1'b0, 1'b0, 20'h0, 3'b000, "R11 same set clash");
        fill_disarm();
        lookup(20'h10008, 12'h0AC, 1'b0, 1'b1, 20'h20008, 3'b101, "R11 fill written");
        lookup(20'h10000, 12'h0AD, 1'b0, 1'b1, 20'h20000, 3'b001, "R11 other way intact");
        fill_arm(20'h10011, 20'h20011, 3'b011);
        lookup(20'h10000, 12'h0AE, 1'b0, 1'b1, 20'h20000, 3'b001, "R11 other set unaffected");
        fill_disarm();
        lookup(20'h10011, 12'h0AF, 1'b0, 1'b1, 20'h20011, 3'b011, "R11 other set fill");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule